// File: doc/BRIEF.md
# Mid-Bit Sampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes for a host. A free-running 16x enable paces the receiver. The line first passes through a small synchronizer. The receiver then watches for a high-to-low transition. It confirms a start bit by sampling half a bit later. After that it samples each data, parity and stop bit at the centre of its bit period. A glitch shorter than half a bit is dropped without effect. The serial format comes from configuration inputs: word length, parity enable, parity sense and forced parity.

A finished character goes into a single-entry holding register. This register keeps the byte together with three tags: parity error, framing error and line break. The host takes the byte with a one-cycle data-read strobe. It clears the sticky status with a one-cycle status-read strobe. If a character finishes while the holding register is still full, the new character is discarded and an overrun flag is raised, so the held byte stays intact. After a break the receiver stays disarmed until the line has returned high.

Top module: `uart_rx_core`

## Requirements
- R1: A character starts only when the synchronized line goes low while the receiver is armed. The line is sampled again 8 ticks later. If it has returned to 1, the start is treated as false, the receiver goes back to idle and no character is produced.
- R2: Each later bit is sampled 16 ticks after the previous sample, least significant bit first. `cfg_wlen` selects 5, 6, 7 or 8 data bits for the codes 00, 01, 10, 11. The received word is right-aligned in `rx_byte` and its unused upper bits are 0.
- R3: When `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_force`=0, `cfg_par_even`=1 expects the XOR of the data bits and `cfg_par_even`=0 expects its inverse. With `cfg_par_force`=1, `cfg_par_even`=1 expects 0 and `cfg_par_even`=0 expects 1. A mismatch sets `parity_err`. When `cfg_par_en`=0 there is no parity bit and `parity_err` stays 0.
- R4: If the first stop bit is sampled as 0, `framing_err` is set. Only one stop bit is checked.
- R5: If every sample of a frame, including the stop bit, is 0, the character is stored as 0x00 with `break_det` and `framing_err` both set.
- R6: After a frame that ends with the line at 0, no new character is assembled until the line has been seen at 1.
- R7: `data_ready` goes to 1 when a character enters the holding register. It goes to 0 on `rd_data`. `rx_byte` keeps its value after the read.
- R8: If a character completes while `data_ready`=1 and `rd_data` is not asserted in that cycle, `overrun` is set. The new character is dropped, and `rx_byte` and the error tags stay unchanged.
- R9: `rd_status` clears `overrun`, `parity_err`, `framing_err` and `break_det`, and leaves `data_ready` unchanged. A character loaded in the same cycle takes precedence.
- R10: After reset, `data_ready`, `overrun`, all tags and `rx_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idles at 1 |
| cfg_wlen | input | 2 | Word length code: 00=5, 01=6, 10=7, 11=8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity, or forced 0 when forcing |
| cfg_par_force | input | 1 | Parity bit is a fixed level |
| rd_data | input | 1 | Host takes the held byte |
| rd_status | input | 1 | Host reads line status, clears sticky flags |
| rx_byte | output | 8 | Held received byte |
| data_ready | output | 1 | Holding register full |
| overrun | output | 1 | A character was dropped because the holding register was full |
| parity_err | output | 1 | Parity tag of the held byte |
| framing_err | output | 1 | Framing tag of the held byte |
| break_det | output | 1 | Break tag of the held byte |

## Verification
Two situations are hardest to reach from the ports. The first is a break whose line is held low well beyond one frame. The bench keeps the line at 0 for several frame times after the break character has been taken, and checks that nothing new is assembled before the line is released. The second is an overrun whose dropped character carries its own error. The bench sends a second character with a bad stop bit while the first is still unread. The held byte must stay intact and its tags must stay clean. A short low pulse, followed by a good frame, checks that a false start is rejected and that the receiver recovers from it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_t;

  // one entry of the holding register: byte plus three tags
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_word_t;

  // number of data bits for a word-length code
  function automatic logic [3:0] word_bits(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  // bits arrive LSB first into the top of the shifter; right-align them
  function automatic logic [7:0] align_word(input logic [7:0] sr, input logic [1:0] wlen);
    return sr >> (2'd3 - wlen);
  endfunction

  // level the parity bit must have for an aligned word
  function automatic logic expect_parity(input logic [7:0] d, input logic even,
                                         input logic force_lvl);
    if (force_lvl) return ~even;
    return even ? ^d : ~^d;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_force,
  output logic       frame_done,
  output rx_word_t   frame,
  output logic       start_seen,
  output logic       false_start,
  output logic       busy
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;

  rx_state_t   state;
  logic [CW-1:0] cnt;
  logic [3:0]  idx;
  logic [7:0]  sr;
  logic        par_smp;
  logic        all_zero;
  logic        armed;

  logic [3:0]  stop_idx;
  logic        half_hit;
  logic        full_hit;
  logic        sample_now;
  logic [7:0]  word;

  assign stop_idx    = word_bits(cfg_wlen) + {3'b000, cfg_par_en};
  assign half_hit    = (cnt == CW'(HALF - 1));
  assign full_hit    = (cnt == CW'(OVERSAMPLE - 1));
  assign start_seen  = tick && (state == ST_IDLE) && !line && armed;
  assign false_start = tick && (state == ST_START) && half_hit && line;
  assign sample_now  = tick && (state == ST_BITS) && full_hit;
  assign frame_done  = sample_now && (idx == stop_idx);
  assign busy        = (state != ST_IDLE);

  assign word       = align_word(sr, cfg_wlen);
  assign frame.data = word;
  assign frame.perr = cfg_par_en &&
                      (par_smp != expect_parity(word, cfg_par_even, cfg_par_force));
  assign frame.ferr = ~line;
  assign frame.brk  = all_zero && ~line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sr       <= '0;
      par_smp  <= 1'b0;
      all_zero <= 1'b0;
      armed    <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (line) armed <= 1'b1;
          else if (armed) begin
            state <= ST_START;
            cnt   <= '0;
            armed <= 1'b0;
          end
        end
        ST_START: begin
          if (half_hit) begin
            cnt <= '0;
            if (line) state <= ST_IDLE;
            else begin
              state    <= ST_BITS;
              idx      <= '0;
              all_zero <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_BITS: begin
          if (full_hit) begin
            cnt      <= '0;
            idx      <= idx + 1'b1;
            all_zero <= all_zero & ~line;
            if (idx < word_bits(cfg_wlen)) sr <= {line, sr[7:1]};
            else if (cfg_par_en && idx == word_bits(cfg_wlen)) par_smp <= line;
            if (idx == stop_idx) state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  rx_word_t   frame,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic       load,
  output logic       drop,
  output logic [7:0] rx_byte,
  output logic       data_ready,
  output logic       overrun,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_det
);
  assign load = frame_done && (!data_ready || rd_data);
  assign drop = frame_done && data_ready && !rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      data_ready  <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      break_det   <= 1'b0;
    end else if (load) begin
      rx_byte     <= frame.data;
      data_ready  <= 1'b1;
      parity_err  <= frame.perr;
      framing_err <= frame.ferr;
      break_det   <= frame.brk;
    end else begin
      if (rd_data) data_ready <= 1'b0;
      if (rd_status) begin
        parity_err  <= 1'b0;
        framing_err <= 1'b0;
        break_det   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (drop)      overrun <= 1'b1;
    else if (rd_status) overrun <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_force,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_byte,
  output logic       data_ready,
  output logic       overrun,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_det
);
  logic     line_s;
  logic     frame_done;
  rx_word_t frame_w;
  logic     start_seen;
  logic     false_start;
  logic     rx_busy;
  logic     held_load;
  logic     held_drop;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (rxd), .dout (line_s)
  );

  uart_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick16),
    .line          (line_s),
    .cfg_wlen      (cfg_wlen),
    .cfg_par_en    (cfg_par_en),
    .cfg_par_even  (cfg_par_even),
    .cfg_par_force (cfg_par_force),
    .frame_done    (frame_done),
    .frame         (frame_w),
    .start_seen    (start_seen),
    .false_start   (false_start),
    .busy          (rx_busy)
  );

  uart_rx_holding u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .frame       (frame_w),
    .rd_data     (rd_data),
    .rd_status   (rd_status),
    .load        (held_load),
    .drop        (held_drop),
    .rx_byte     (rx_byte),
    .data_ready  (data_ready),
    .overrun     (overrun),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .break_det   (break_det)
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_data,
  input logic       rd_status,
  input logic       frame_done,
  input logic       frame_brk,
  input logic       start_seen,
  input logic       false_start,
  input logic       busy,
  input logic       held_load,
  input logic       held_drop,
  input logic [7:0] rx_byte,
  input logic       data_ready,
  input logic       overrun,
  input logic       parity_err,
  input logic       framing_err,
  input logic       break_det
);
  // R1: a rejected start returns the receiver to idle
  assert_false_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> !busy);

  // R1: a start is only taken from idle
  assert_start_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |-> !busy);

  // R5: an all-zero frame lands with break and framing tags and a zero byte
  assert_break_tags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_brk && !data_ready) |=> (break_det && framing_err && rx_byte == 8'h00));

  // R7: a completed character into an empty holder raises ready
  assert_load_sets_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !data_ready) |=> data_ready);

  // R7: a host data read with no arriving character empties the holder
  assert_read_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !frame_done) |=> !data_ready);

  // R8: a character arriving into a full holder is dropped, byte kept
  assert_overrun_keeps_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && data_ready && !rd_data) |=> (overrun && $stable(rx_byte)));

  // R8: a character is either stored or dropped, never both
  assert_load_drop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({held_load, held_drop}));

  // R9: a status read clears the sticky flags
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !frame_done) |=> (!overrun && !parity_err && !framing_err && !break_det));
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_data     (rd_data),
  .rd_status   (rd_status),
  .frame_done  (frame_done),
  .frame_brk   (frame_w.brk),
  .start_seen  (start_seen),
  .false_start (false_start),
  .busy        (rx_busy),
  .held_load   (held_load),
  .held_drop   (held_drop),
  .rx_byte     (rx_byte),
  .data_ready  (data_ready),
  .overrun     (overrun),
  .parity_err  (parity_err),
  .framing_err (framing_err),
  .break_det   (break_det)
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_force = 1'b0;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_byte;
  logic       data_ready, overrun, parity_err, framing_err, break_det;

  int total = 0;
  int bad = 0;
  logic [1:0] tdiv;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign tick16 = (tdiv == 2'd3);

  uart_rx_core u_uart_rx_core (
    .clk (clk), .rst_n (rst_n), .tick16 (tick16), .rxd (rxd),
    .cfg_wlen (cfg_wlen), .cfg_par_en (cfg_par_en), .cfg_par_even (cfg_par_even),
    .cfg_par_force (cfg_par_force), .rd_data (rd_data), .rd_status (rd_status),
    .rx_byte (rx_byte), .data_ready (data_ready), .overrun (overrun),
    .parity_err (parity_err), .framing_err (framing_err), .break_det (break_det)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_wait(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  function automatic logic ones_odd(input logic [7:0] d, input int nb);
    logic acc = 1'b0;
    for (int i = 0; i < nb; i++) acc = acc ^ d[i];
    return acc;
  endfunction

  task automatic send_char(input logic [7:0] d, input int nb, input bit use_par,
                           input bit pbit, input bit stopv);
    rxd = 1'b0;
    bit_wait(1);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      bit_wait(1);
    end
    if (use_par) begin
      rxd = pbit;
      bit_wait(1);
    end
    rxd = stopv;
    bit_wait(1);
    rxd = 1'b1;
    bit_wait(1);
  endtask

  task automatic pulse_rd_data();
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
  endtask

  task automatic pulse_rd_status();
    @(negedge clk) rd_status = 1'b1;
    @(negedge clk) rd_status = 1'b0;
  endtask

  task automatic drain();
    pulse_rd_data();
    pulse_rd_status();
  endtask

  task automatic t_reset();
    chk("R10 data_ready", data_ready, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 tags", {parity_err, framing_err, break_det}, 0);
    chk("R10 rx_byte", rx_byte, 0);
  endtask

  task automatic t_basic_8n1();
    cfg_wlen = 2'b11; cfg_par_en = 0;
    send_char(8'hA5, 8, 0, 0, 1);
    chk("R2 byte 8N1", rx_byte, 8'hA5);
    chk("R7 ready set", data_ready, 1);
    chk("R3 no parity err", parity_err, 0);
    chk("R4 no framing err", framing_err, 0);
    pulse_rd_data();
    chk("R7 ready cleared", data_ready, 0);
    chk("R7 byte kept", rx_byte, 8'hA5);
  endtask

  task automatic t_lengths_parity();
    logic [7:0] d;
    // 5 bits, even parity
    cfg_wlen = 2'b00; cfg_par_en = 1; cfg_par_even = 1; cfg_par_force = 0;
    d = 8'hFD;
    send_char(d, 5, 1, ones_odd(d, 5), 1);
    chk("R2 5-bit aligned", rx_byte, 8'h1D);
    chk("R3 even ok", parity_err, 0);
    drain();
    // 7 bits, odd parity
    cfg_wlen = 2'b10; cfg_par_even = 0;
    d = 8'h4B;
    send_char(d, 7, 1, ~ones_odd(d, 7), 1);
    chk("R2 7-bit word", rx_byte, 8'h4B);
    chk("R3 odd ok", parity_err, 0);
    drain();
    // 6 bits, odd parity, wrong bit sent
    cfg_wlen = 2'b01;
    d = 8'h2C;
    send_char(d, 6, 1, ones_odd(d, 6), 1);
    chk("R2 6-bit word", rx_byte, 8'h2C);
    chk("R3 bad parity flagged", parity_err, 1);
    pulse_rd_status();
    chk("R9 status read clears parity", parity_err, 0);
    chk("R9 status read keeps ready", data_ready, 1);
    pulse_rd_data();
  endtask

  task automatic t_forced_parity();
    cfg_wlen = 2'b11; cfg_par_en = 1; cfg_par_force = 1;
    cfg_par_even = 0; // fixed 1 expected
    send_char(8'h01, 8, 1, 1, 1);
    chk("R3 force mark ok", parity_err, 0);
    drain();
    send_char(8'h01, 8, 1, 0, 1);
    chk("R3 force mark mismatch", parity_err, 1);
    drain();
    cfg_par_even = 1; // fixed 0 expected
    send_char(8'h01, 8, 1, 0, 1);
    chk("R3 force space ok", parity_err, 0);
    drain();
    cfg_par_force = 0; cfg_par_en = 0;
  endtask

  task automatic t_framing();
    cfg_wlen = 2'b11; cfg_par_en = 0;
    send_char(8'h81, 8, 0, 0, 0);
    chk("R4 framing flagged", framing_err, 1);
    chk("R4 byte stored", rx_byte, 8'h81);
    chk("R5 not break", break_det, 0);
    drain();
    chk("R9 framing cleared", framing_err, 0);
  endtask

  task automatic t_break();
    cfg_wlen = 2'b11; cfg_par_en = 0;
    rxd = 1'b0;
    bit_wait(11);
    chk("R5 break ready", data_ready, 1);
    chk("R5 break tag", break_det, 1);
    chk("R5 break framing", framing_err, 1);
    chk("R5 break byte", rx_byte, 8'h00);
    drain();
    bit_wait(25);
    chk("R6 no char while low", data_ready, 0);
    chk("R9 break cleared", break_det, 0);
    rxd = 1'b1;
    bit_wait(1);
    send_char(8'h3C, 8, 0, 0, 1);
    chk("R6 rearmed char", rx_byte, 8'h3C);
    chk("R6 rearmed ready", data_ready, 1);
    pulse_rd_data();
  endtask

  task automatic t_overrun();
    cfg_wlen = 2'b11; cfg_par_en = 0;
    send_char(8'h11, 8, 0, 0, 1);
    send_char(8'h22, 8, 0, 0, 0);
    chk("R8 overrun set", overrun, 1);
    chk("R8 held byte kept", rx_byte, 8'h11);
    chk("R8 held tags kept", framing_err, 0);
    pulse_rd_status();
    chk("R9 overrun cleared", overrun, 0);
    pulse_rd_data();
    chk("R7 ready after overrun read", data_ready, 0);
  endtask

  task automatic t_glitch();
    cfg_wlen = 2'b11; cfg_par_en = 0;
    rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    bit_wait(2);
    chk("R1 glitch ignored", data_ready, 0);
    send_char(8'h5A, 8, 0, 0, 1);
    chk("R1 recovered byte", rx_byte, 8'h5A);
    chk("R1 recovered ready", data_ready, 1);
    pulse_rd_data();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    bit_wait(1);
    t_reset();
    t_basic_8n1();
    t_lengths_parity();
    t_forced_parity();
    t_framing();
    t_break();
    t_overrun();
    t_glitch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule